// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block is a two-sided byte mailbox that sits between a host bus agent and a management controller. Each direction carries one byte at a time. The host writes into an inbound data register, and the controller reads it. The controller writes into an outbound data register, and the host reads it. A shared eight-bit status register tells both sides which buffer is holding unread data. The same register also carries a command/data marker and five protocol bits that only the controller can write.

Both sides reach the block through a small register port: an address, a write strobe, a read strobe and write data, with read data returned in the same cycle. Each side has one level interrupt. The interrupt is asserted while the buffer addressed to that side holds unread data and that side has enabled it.

Writing a data register raises the remote interrupt. Writing the status register never does. Because of this, a protocol that changes the status bits must follow the status write with a dummy data write if it wants the peer to notice.

Top module: `byte_mailbox`

## Requirements
- R1: After reset the following are all zero: both data registers, every status bit, both interrupt enables, both overrun bits, and both interrupt outputs.
- R2: A host write at address 0 (data) performs three actions: it loads the inbound register, it sets status bit 1 (inbound full), and it clears status bit 3 (command/data marker).
- R3: A host write at address 1 (command) loads the inbound register, sets status bit 1, and sets status bit 3.
- R4: A controller read at address 0 returns the inbound byte and clears status bit 1. Status bit 3 keeps its value.
- R5: A controller write at address 0 loads the outbound register and sets status bit 0 (outbound full). A host read at address 0 returns that byte and clears status bit 0.
- R6: A controller write at address 1 updates only status bits 7, 6, 5, 4 and 2. Bits 0, 1 and 3 stay hardware-owned. A host read at address 1 returns the whole status byte, and the host has no way to write it.
- R7: A controller status write never raises the host interrupt.
- R8: The controller interrupt equals inbound-full AND the controller enable, which is bit 0 of controller address 2. The host interrupt equals outbound-full AND the host enable, which is bit 0 of host address 2.
- R9: A data write into a buffer that is already full, with no drain in the same cycle, has two effects. The new byte replaces the old one and the full flag stays set. A sticky overrun bit is also set: controller address 2 bit 2 for the inbound buffer, bit 3 for the outbound buffer. Each overrun bit clears only when a 1 is written to it.
- R10: A write and a drain of the same buffer in the same cycle leave the full flag set and the new byte stored, and they do not count as an overrun. The read returns the old byte.
- R11: A status read by either side leaves every flag and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 2 | Host address: 0 data, 1 command/status, 2 enable |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| h_irq | output | 1 | Host interrupt level |
| c_wr | input | 1 | Controller write strobe |
| c_rd | input | 1 | Controller read strobe |
| c_addr | input | 2 | Controller address: 0 data, 1 status, 2 control |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data |
| c_irq | output | 1 | Controller interrupt level |

## Verification
The hardest case to reach is a write and a drain of the same buffer landing on one clock edge. In that case the read must still return the old byte, the flag must stay set, and no overrun may be recorded. The bench reaches it by driving the host data write and the controller data read in a single cycle, and only after a first byte is already waiting. Overruns in both directions are produced by back-to-back writes with no read between them. Each overrun bit is then cleared by a write-one, and the bench checks the other control bits at the same time.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    // Status bit positions; peers decode these
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_CD  = 3;
    localparam byte_t ST_SW_MASK = 8'hF4;

    // Controller control register bit positions
    localparam int CT_IE      = 0;
    localparam int CT_OVR_IN  = 2;
    localparam int CT_OVR_OUT = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA = 2'd0,
        A_CSR  = 2'd1,
        A_CTRL = 2'd2,
        A_RSVD = 2'd3
    } addr_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        byte_t wdata;
    } buf_req_t;

    function automatic byte_t status_pack(byte_t sw, logic cd, logic ibf, logic obf);
        byte_t s;
        s = sw & ST_SW_MASK;
        s[ST_CD]  = cd;
        s[ST_IBF] = ibf;
        s[ST_OBF] = obf;
        return s;
    endfunction

endpackage

// File: rtl/mbx_buffer.sv
module mbx_buffer
    import mbx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  buf_req_t req,
    input  logic     ovr_clr,
    output byte_t    data,
    output logic     full,
    output logic     ovr
);

    byte_t data_q;
    logic  full_q;
    logic  ovr_q;
    logic  overwrite;

    assign overwrite = req.wr && full_q && !req.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (req.wr) begin
                data_q <= req.wdata;
            end
            if (req.wr) begin
                full_q <= 1'b1;
            end else if (req.rd) begin
                full_q <= 1'b0;
            end
            if (overwrite) begin
                ovr_q <= 1'b1;
            end else if (ovr_clr) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign data = data_q;
    assign full = full_q;
    assign ovr  = ovr_q;

    p_wr_sets_full_r2: assert property (@(posedge clk) disable iff (rst)
        req.wr |=> full);

    p_rd_clears_full_r4: assert property (@(posedge clk) disable iff (rst)
        (req.rd && !req.wr) |=> !full);

    p_overwrite_flags_r9: assert property (@(posedge clk) disable iff (rst)
        (req.wr && full && !req.rd) |=> (ovr && full));

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr) |=> ovr);

    p_same_cycle_no_ovr_r10: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.rd && !ovr) |=> (full && !ovr));

    p_data_holds_r11: assert property (@(posedge clk) disable iff (rst)
        !req.wr |=> $stable(data));

endmodule

// File: rtl/mbx_status.sv
module mbx_status
    import mbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sw_wr,
    input  byte_t sw_wdata,
    input  logic  cd_set,
    input  logic  cd_clr,
    input  logic  ibf,
    input  logic  obf,
    output byte_t status
);

    byte_t sw_q;
    logic  cd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q <= '0;
            cd_q <= 1'b0;
        end else begin
            if (sw_wr) begin
                sw_q <= sw_wdata & ST_SW_MASK;
            end
            if (cd_set) begin
                cd_q <= 1'b1;
            end else if (cd_clr) begin
                cd_q <= 1'b0;
            end
        end
    end

    assign status = status_pack(sw_q, cd_q, ibf, obf);

    p_cmd_marks_cd_r3: assert property (@(posedge clk) disable iff (rst)
        cd_set |=> status[ST_CD]);

    p_data_clears_cd_r2: assert property (@(posedge clk) disable iff (rst)
        (cd_clr && !cd_set) |=> !status[ST_CD]);

    p_sw_bits_follow_r6: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> ((status & ST_SW_MASK) == ($past(sw_wdata) & ST_SW_MASK)));

    p_cd_kept_on_sw_r6: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && !cd_set && !cd_clr) |=> $stable(status[ST_CD]));

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq (
    input  logic clk,
    input  logic rst,
    input  logic en_wr,
    input  logic en_wdata,
    input  logic full,
    output logic en,
    output logic irq
);

    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end

    assign en  = en_q;
    assign irq = full && en_q;

    p_irq_drops_on_disable_r8: assert property (@(posedge clk) disable iff (rst)
        (en_wr && !en_wdata) |=> !irq);

endmodule

// File: rtl/byte_mailbox.sv
module byte_mailbox
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [BYTE_W-1:0] h_wdata,
    output logic [BYTE_W-1:0] h_rdata,
    output logic              h_irq,
    input  logic              c_wr,
    input  logic              c_rd,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [BYTE_W-1:0] c_wdata,
    output logic [BYTE_W-1:0] c_rdata,
    output logic              c_irq
);

    // Address decode
    logic h_wr_data, h_wr_cmd, h_wr_ctrl, h_rd_data;
    logic c_wr_data, c_wr_stat, c_wr_ctrl, c_rd_data;

    assign h_wr_data = h_wr && (h_addr == A_DATA);
    assign h_wr_cmd  = h_wr && (h_addr == A_CSR);
    assign h_wr_ctrl = h_wr && (h_addr == A_CTRL);
    assign h_rd_data = h_rd && (h_addr == A_DATA);

    assign c_wr_data = c_wr && (c_addr == A_DATA);
    assign c_wr_stat = c_wr && (c_addr == A_CSR);
    assign c_wr_ctrl = c_wr && (c_addr == A_CTRL);
    assign c_rd_data = c_rd && (c_addr == A_DATA);

    buf_req_t in_req, out_req;
    byte_t    in_data, out_data, status;
    logic     ibf, obf, ovr_in, ovr_out;
    logic     h_en, c_en;

    assign in_req  = '{wr: h_wr_data || h_wr_cmd, rd: c_rd_data, wdata: h_wdata};
    assign out_req = '{wr: c_wr_data, rd: h_rd_data, wdata: c_wdata};

    mbx_buffer u_inbound (
        .clk     (clk),
        .rst     (rst),
        .req     (in_req),
        .ovr_clr (c_wr_ctrl && c_wdata[CT_OVR_IN]),
        .data    (in_data),
        .full    (ibf),
        .ovr     (ovr_in)
    );

    mbx_buffer u_outbound (
        .clk     (clk),
        .rst     (rst),
        .req     (out_req),
        .ovr_clr (c_wr_ctrl && c_wdata[CT_OVR_OUT]),
        .data    (out_data),
        .full    (obf),
        .ovr     (ovr_out)
    );

    mbx_status u_status (
        .clk      (clk),
        .rst      (rst),
        .sw_wr    (c_wr_stat),
        .sw_wdata (c_wdata),
        .cd_set   (h_wr_cmd),
        .cd_clr   (h_wr_data),
        .ibf      (ibf),
        .obf      (obf),
        .status   (status)
    );

    mbx_irq u_c_irq (
        .clk      (clk),
        .rst      (rst),
        .en_wr    (c_wr_ctrl),
        .en_wdata (c_wdata[CT_IE]),
        .full     (ibf),
        .en       (c_en),
        .irq      (c_irq)
    );

    mbx_irq u_h_irq (
        .clk      (clk),
        .rst      (rst),
        .en_wr    (h_wr_ctrl),
        .en_wdata (h_wdata[0]),
        .full     (obf),
        .en       (h_en),
        .irq      (h_irq)
    );

    // Read muxes
    always_comb begin
        h_rdata = '0;
        case (h_addr)
            A_DATA:  h_rdata = out_data;
            A_CSR:   h_rdata = status;
            A_CTRL:  h_rdata[0] = h_en;
            default: h_rdata = '0;
        endcase
    end

    always_comb begin
        c_rdata = '0;
        case (c_addr)
            A_DATA:  c_rdata = in_data;
            A_CSR:   c_rdata = status;
            A_CTRL: begin
                c_rdata[CT_IE]      = c_en;
                c_rdata[CT_OVR_IN]  = ovr_in;
                c_rdata[CT_OVR_OUT] = ovr_out;
            end
            default: c_rdata = '0;
        endcase
    end

    p_status_wr_no_host_irq_r7: assert property (@(posedge clk) disable iff (rst)
        (c_wr_stat && !h_irq && !h_wr) |=> !h_irq);

    p_out_wr_raises_host_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (c_wr_data && h_en && !h_wr) |=> h_irq);

    p_in_wr_raises_ctl_irq_r8: assert property (@(posedge clk) disable iff (rst)
        ((h_wr_data || h_wr_cmd) && c_en && !c_wr) |=> c_irq);

    p_status_rd_keeps_flags_r11: assert property (@(posedge clk) disable iff (rst)
        (c_rd && c_addr == A_CSR && !c_wr && !h_wr && !h_rd) |=> ($stable(status) && $stable(c_irq) && $stable(h_irq)));

endmodule

// File: tb/byte_mailbox_test.sv
module byte_mailbox_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_wr = 0, h_rd = 0, c_wr = 0, c_rd = 0;
    logic [1:0] h_addr = 0, c_addr = 0;
    logic [7:0] h_wdata = 0, c_wdata = 0;
    logic [7:0] h_rdata, c_rdata;
    logic       h_irq, c_irq;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit         host_side;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    byte_mailbox uut (
        .clk(clk), .rst(rst),
        .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_irq(h_irq),
        .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata),
        .c_rdata(c_rdata), .c_irq(c_irq)
    );

    task automatic report(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data mid-cycle against the scoreboard
    always @(negedge clk) begin
        if (c_rd || h_rd) begin
            if (sb_q.size() == 0) begin
                report("scoreboard-empty", 8'h00, 8'h01);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                report(it.tag, it.host_side ? h_rdata : c_rdata, it.exp);
            end
        end
    end

    task automatic h_write(logic [1:0] a, logic [7:0] d);
        @(posedge clk); #1;
        h_wr = 1; h_addr = a; h_wdata = d;
        @(posedge clk); #1;
        h_wr = 0;
    endtask

    task automatic c_write(logic [1:0] a, logic [7:0] d);
        @(posedge clk); #1;
        c_wr = 1; c_addr = a; c_wdata = d;
        @(posedge clk); #1;
        c_wr = 0;
    endtask

    task automatic h_read(logic [1:0] a, logic [7:0] exp, string tag);
        @(posedge clk); #1;
        sb_q.push_back('{host_side: 1'b1, exp: exp, tag: tag});
        h_rd = 1; h_addr = a;
        @(posedge clk); #1;
        h_rd = 0;
    endtask

    task automatic c_read(logic [1:0] a, logic [7:0] exp, string tag);
        @(posedge clk); #1;
        sb_q.push_back('{host_side: 1'b0, exp: exp, tag: tag});
        c_rd = 1; c_addr = a;
        @(posedge clk); #1;
        c_rd = 0;
    endtask

    task automatic chk_irqs(logic ce, logic he, string tag);
        @(negedge clk);
        report({tag, " c_irq"}, {7'b0, c_irq}, {7'b0, ce});
        report({tag, " h_irq"}, {7'b0, h_irq}, {7'b0, he});
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        chk_irqs(0, 0, "R1 reset");
        c_read(1, 8'h00, "R1 status");
        c_read(2, 8'h00, "R1 ctrl");
        c_read(0, 8'h00, "R1 inbound");
        h_read(0, 8'h00, "R1 outbound");
        h_read(2, 8'h00, "R1 host enable");

        c_write(2, 8'h01);
        h_write(2, 8'h01);
        chk_irqs(0, 0, "R8 enabled idle");

        // R2 / R4 data path host->controller
        h_write(0, 8'h5A);
        chk_irqs(1, 0, "R8 inbound full");
        h_read(1, 8'h02, "R2 status after data write");
        c_read(0, 8'h5A, "R4 inbound byte");
        c_read(1, 8'h00, "R4 status after drain");
        chk_irqs(0, 0, "R4 irq acked");

        // R3 command write
        h_write(1, 8'hC3);
        h_read(1, 8'h0A, "R3 status after command");
        c_read(0, 8'hC3, "R3 inbound byte");
        c_read(1, 8'h08, "R4 cd kept after drain");

        // R6 / R7 status write
        c_write(1, 8'hFF);
        chk_irqs(0, 0, "R7 status write");
        h_read(1, 8'hFC, "R6 masked status");

        // R5 controller->host
        c_write(0, 8'h81);
        chk_irqs(0, 1, "R8 outbound full");
        h_read(1, 8'hFD, "R5 status obf");
        h_read(0, 8'h81, "R5 outbound byte");
        h_read(1, 8'hFC, "R5 obf cleared");
        chk_irqs(0, 0, "R5 irq acked");

        // R9 overrun inbound
        h_write(0, 8'h11);
        h_write(0, 8'h22);
        c_read(2, 8'h05, "R9 inbound overrun");
        c_read(0, 8'h22, "R9 newest byte");
        c_read(1, 8'hF4, "R9 status after drain");
        c_write(2, 8'h05);
        c_read(2, 8'h01, "R9 w1c inbound");

        // R9 overrun outbound
        c_write(0, 8'h33);
        c_write(0, 8'h44);
        c_read(2, 8'h09, "R9 outbound overrun");
        h_read(0, 8'h44, "R9 outbound newest");
        c_write(2, 8'h09);
        c_read(2, 8'h01, "R9 w1c outbound");

        // R10 write and drain in one cycle
        h_write(0, 8'hAA);
        @(posedge clk); #1;
        sb_q.push_back('{host_side: 1'b0, exp: 8'hAA, tag: "R10 old byte on read"});
        c_rd = 1; c_addr = 0;
        h_wr = 1; h_addr = 0; h_wdata = 8'h55;
        @(posedge clk); #1;
        c_rd = 0; h_wr = 0;
        chk_irqs(1, 0, "R10 flag stays");
        c_read(2, 8'h01, "R10 no overrun");
        c_read(0, 8'h55, "R10 new byte");

        // R11 status reads leave state alone
        h_write(0, 8'h77);
        c_write(0, 8'h66);
        c_read(1, 8'hF7, "R11 status read 1");
        h_read(1, 8'hF7, "R11 status read 2");
        c_read(1, 8'hF7, "R11 status read 3");
        chk_irqs(1, 1, "R11 irqs kept");

        // R8 disable masks the level
        c_write(2, 8'h00);
        h_write(2, 8'h00);
        chk_irqs(0, 0, "R8 disabled");
        h_read(1, 8'hF7, "R8 flags kept while masked");

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule